// File: doc/BRIEF.md
# Staggered Partial-Rank Refresh Controller

This block is the refresh engine of a memory controller for one rank. The chips of the rank are split into `NUM_GROUPS` equal groups. Each group is refreshed on its own, in a fixed rotation, one group per slot of `TREFI_CYC / NUM_GROUPS` cycles. Two groups are never busy at once. While one group is refreshing, the other chips of every memory block can still be read. For each read, the controller gives a per-chip erasure mask that names the chip positions inside their refresh cycle time. A downstream redundancy decoder uses this mask to rebuild the missing symbols, so the read never waits.

When a hardware fault is being corrected, the redundancy is no longer spare. The controller is then told to switch to fault mode. In that mode it issues one whole-rank refresh every `TREFI_CYC` cycles and stalls reads for its duration. In normal mode it may also issue group refreshes early, during quiet periods, and bank up to `MAX_CREDIT` credits. Each credit absorbs one later scheduled slot. Writes to a group that is refreshing are held off until the group's busy timer runs out.

Top module: `rfsh_ctrl`

## Requirements
- R1: While `rst_n` is low, `ref_cmd_valid` and `rd_stall` are 0, `rd_erase` is all zero and `wr_ready` is 1.
- R2: In normal mode with no early refreshes, a command issues every `SLOT_CYC = TREFI_CYC/NUM_GROUPS` cycles. It appears in cycle n*SLOT_CYC after reset release (n = 1, 2, ...) and targets group (n-1) mod NUM_GROUPS. `ref_grp_mask` bit g selects group g.
- R3: A group command has exactly one bit of `ref_grp_mask` set. A whole-rank command has all bits set. At most one group is busy at a time outside whole-rank refresh.
- R4: `rd_erase` bit c refers to chip c, which belongs to group c / CHIPS_PER_GROUP. In the same cycle as `rd_valid`, a bit is set exactly for the chips of a busy group, when not in whole-rank refresh. The mask is zero when `rd_valid` is low.
- R5: In normal mode `rd_stall` stays 0.
- R6: `wr_ready` is 0 exactly while the group selected by `wr_grp` is busy.
- R7: In normal mode with `pullin_ok` high, an early group refresh issues when three conditions hold: no group is busy, the slot counter is below SLOT_CYC-TRFC_CYC-1, and fewer than MAX_CREDIT credits are held. A scheduled slot that finds a credit consumes it and issues nothing.
- R8: Early refreshes never put the rotation more than MAX_CREDIT commands ahead of the slot schedule. With `pullin_ok` held high, the lead settles at exactly MAX_CREDIT.
- R9: In fault mode, no group refreshes issue. On every NUM_GROUPS-th slot tick, a whole-rank command issues, credits are cleared, and `rd_stall` is 1 with `rd_erase` zero for the busy duration.
- R10: A group stays busy for exactly TRFC_CYC cycles, starting in the cycle its command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_mode | input | 1 | 1 = fault correction active, whole-rank blocking refresh |
| pullin_ok | input | 1 | Quiet period, early group refresh allowed |
| rd_valid | input | 1 | A read is issued this cycle |
| rd_erase | output | NUM_GROUPS*CHIPS_PER_GROUP | Per-chip erasure mask for the read |
| rd_stall | output | 1 | Read must wait (whole-rank refresh busy) |
| wr_grp | input | clog2(NUM_GROUPS) | Group targeted by a pending write |
| wr_ready | output | 1 | The targeted group may accept the write |
| ref_cmd_valid | output | 1 | Refresh command issued this cycle |
| ref_grp_mask | output | NUM_GROUPS | Groups addressed by the refresh command |

## Verification
The bench builds the block with four groups of two chips, a 400-cycle rank interval (100-cycle slots), a 30-cycle busy time and eight credits. The short slot lets the bench cover several full rotations and the filling of the whole credit bank. It also covers a fault-mode stretch spanning two whole-rank refreshes and the return to rotation, all within a few thousand cycles. With a 30-cycle busy time, up to three early refreshes fit into one slot's window, so the credit limit is reached and held.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ISSUE_NONE  = 2'd0,
    ISSUE_GROUP = 2'd1,
    ISSUE_RANK  = 2'd2
  } issue_e;

  function automatic int ptr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rfsh_slot_timer.sv
module rfsh_slot_timer #(
  parameter int SLOT_CYC   = 100,
  parameter int NUM_GROUPS = 4,
  parameter int TRFC_CYC   = 30
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic slot_last,
  output logic pull_window
);
  localparam int CW = $clog2(SLOT_CYC);
  localparam int SW = rfsh_pkg::ptr_width(NUM_GROUPS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sidx_q, sidx_d;

  assign tick        = (cnt_q == CW'(SLOT_CYC - 1));
  assign slot_last   = (sidx_q == SW'(NUM_GROUPS - 1));
  assign pull_window = (cnt_q < CW'(SLOT_CYC - TRFC_CYC - 1));

  always_comb begin
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    sidx_d = sidx_q;
    if (tick) sidx_d = slot_last ? '0 : sidx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sidx_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sidx_q <= sidx_d;
    end
  end
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int MAX_CREDIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic use_one,
  input  logic clear,
  output logic has_credit,
  output logic full
);
  localparam int KW = $clog2(MAX_CREDIT + 1);

  logic [KW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign has_credit = (cnt_q != '0);
  assign full       = (cnt_q == KW'(MAX_CREDIT));
  assign cnt_en     = clear | (add & ~full) | (use_one & has_credit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                   cnt_d = '0;
    else if (add && !full)       cnt_d = cnt_q + 1'b1;
    else if (use_one && has_credit) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_busy_bank.sv
module rfsh_busy_bank #(
  parameter int NUM_GROUPS = 4,
  parameter int TRFC_CYC   = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] load,
  output logic [NUM_GROUPS-1:0] busy
);
  localparam int TW = $clog2(TRFC_CYC + 1);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [TW-1:0] tmr_q, tmr_d;
    logic          tmr_en;

    assign busy[g] = (tmr_q != '0);
    assign tmr_en  = load[g] | busy[g];

    always_comb begin
      tmr_d = load[g] ? TW'(TRFC_CYC) : tmr_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tmr_q <= '0;
      else if (tmr_en) tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/rfsh_erase_map.sv
module rfsh_erase_map #(
  parameter int NUM_GROUPS      = 4,
  parameter int CHIPS_PER_GROUP = 2
) (
  input  logic                                  rd_valid,
  input  logic                                  rank_mode,
  input  logic [NUM_GROUPS-1:0]                 busy,
  output logic [NUM_GROUPS*CHIPS_PER_GROUP-1:0] erase
);
  for (genvar c = 0; c < NUM_GROUPS * CHIPS_PER_GROUP; c++) begin : g_chip
    assign erase[c] = rd_valid & ~rank_mode & busy[c / CHIPS_PER_GROUP];
  end
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int NUM_GROUPS      = 4,
  parameter int CHIPS_PER_GROUP = 2,
  parameter int TREFI_CYC       = 400,
  parameter int TRFC_CYC        = 30,
  parameter int MAX_CREDIT      = 8,
  localparam int NUM_CHIPS      = NUM_GROUPS * CHIPS_PER_GROUP,
  localparam int GW             = rfsh_pkg::ptr_width(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fault_mode,
  input  logic                  pullin_ok,
  input  logic                  rd_valid,
  output logic [NUM_CHIPS-1:0]  rd_erase,
  output logic                  rd_stall,
  input  logic [GW-1:0]         wr_grp,
  output logic                  wr_ready,
  output logic                  ref_cmd_valid,
  output logic [NUM_GROUPS-1:0] ref_grp_mask
);
  localparam int SLOT_CYC = TREFI_CYC / NUM_GROUPS;

  logic tick, slot_last, pull_window;
  logic has_credit, credit_full;
  logic cred_add, cred_use, cred_clr;
  logic [NUM_GROUPS-1:0] busy, issue_mask;
  logic any_busy;
  issue_e kind;

  logic [GW-1:0]         ptr_q, ptr_d;
  logic                  cmd_q, cmd_d;
  logic [NUM_GROUPS-1:0] mask_q, mask_d;
  logic                  rank_q, rank_d;
  logic                  issue_en;

  rfsh_slot_timer #(
    .SLOT_CYC(SLOT_CYC), .NUM_GROUPS(NUM_GROUPS), .TRFC_CYC(TRFC_CYC)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .slot_last(slot_last), .pull_window(pull_window)
  );

  rfsh_credit #(.MAX_CREDIT(MAX_CREDIT)) u_credit (
    .clk(clk), .rst_n(rst_n), .add(cred_add), .use_one(cred_use),
    .clear(cred_clr), .has_credit(has_credit), .full(credit_full)
  );

  rfsh_busy_bank #(.NUM_GROUPS(NUM_GROUPS), .TRFC_CYC(TRFC_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(issue_mask), .busy(busy)
  );

  rfsh_erase_map #(.NUM_GROUPS(NUM_GROUPS), .CHIPS_PER_GROUP(CHIPS_PER_GROUP)) u_erase (
    .rd_valid(rd_valid), .rank_mode(rank_q), .busy(busy), .erase(rd_erase)
  );

  assign any_busy = |busy;

  // Issue decision: scheduled slot first, early refresh only off the tick
  always_comb begin
    kind     = ISSUE_NONE;
    cred_add = 1'b0;
    cred_use = 1'b0;
    cred_clr = 1'b0;
    if (tick) begin
      if (fault_mode) begin
        if (slot_last) begin
          kind     = ISSUE_RANK;
          cred_clr = 1'b1;
        end
      end else if (has_credit) begin
        cred_use = 1'b1;
      end else begin
        kind = ISSUE_GROUP;
      end
    end else if (!fault_mode && pullin_ok && pull_window && !any_busy && !credit_full) begin
      kind     = ISSUE_GROUP;
      cred_add = 1'b1;
    end
  end

  always_comb begin
    case (kind)
      ISSUE_GROUP: issue_mask = NUM_GROUPS'(1) << ptr_q;
      ISSUE_RANK:  issue_mask = '1;
      default:     issue_mask = '0;
    endcase
  end

  assign issue_en = (kind != ISSUE_NONE);

  always_comb begin
    ptr_d  = ptr_q;
    cmd_d  = issue_en;
    mask_d = issue_en ? issue_mask : mask_q;
    rank_d = issue_en ? (kind == ISSUE_RANK) : rank_q;
    if (kind == ISSUE_GROUP)
      ptr_d = (ptr_q == GW'(NUM_GROUPS - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cmd_q  <= 1'b0;
      mask_q <= '0;
      rank_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      if (issue_en) begin
        ptr_q  <= ptr_d;
        mask_q <= mask_d;
        rank_q <= rank_d;
      end
    end
  end

  assign ref_cmd_valid = cmd_q;
  assign ref_grp_mask  = cmd_q ? mask_q : '0;
  assign rd_stall      = rank_q & any_busy;
  assign wr_ready      = ~busy[wr_grp];
endmodule

// File: rtl/rfsh_ctrl_chk.sv
module rfsh_ctrl_chk #(
  parameter int G     = 4,
  parameter int NCHIP = 8,
  parameter int GW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_cmd_valid,
  input logic [G-1:0]     ref_grp_mask,
  input logic             rd_valid,
  input logic [NCHIP-1:0] rd_erase,
  input logic             rd_stall,
  input logic [GW-1:0]    wr_grp,
  input logic             wr_ready
);
  a_r3_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd_valid |-> ($onehot(ref_grp_mask) || (&ref_grp_mask)));

  a_r4_erase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_erase == '0));

  a_r5_group_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd_valid && $onehot(ref_grp_mask)) |-> !rd_stall);

  a_r9_rank_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd_valid && (&ref_grp_mask)) |-> (rd_stall && rd_erase == '0));

  a_r6_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd_valid && ref_grp_mask[wr_grp]) |-> !wr_ready);

  a_r10_cmd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd_valid |=> !ref_cmd_valid);
endmodule

bind rfsh_ctrl rfsh_ctrl_chk #(.G(NUM_GROUPS), .NCHIP(NUM_CHIPS), .GW(GW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_cmd_valid(ref_cmd_valid),
  .ref_grp_mask(ref_grp_mask), .rd_valid(rd_valid), .rd_erase(rd_erase),
  .rd_stall(rd_stall), .wr_grp(wr_grp), .wr_ready(wr_ready)
);

// File: tb/rfsh_ctrl_tb_top.sv
`timescale 1ns/1ps
module rfsh_ctrl_tb_top;
  localparam int G = 4, CPG = 2, NCHIP = G * CPG, GW = 2;
  localparam int TREFI = 400, SLOT = TREFI / G, TRFC = 30, MAXC = 8;

  logic clk = 1'b0;
  logic rst_n, fault_mode, pullin_ok, rd_valid, rd_stall, wr_ready, ref_cmd_valid;
  logic [NCHIP-1:0] rd_erase;
  logic [GW-1:0]    wr_grp;
  logic [G-1:0]     ref_grp_mask;

  always #4 clk = ~clk;

  rfsh_ctrl #(.NUM_GROUPS(G), .CHIPS_PER_GROUP(CPG), .TREFI_CYC(TREFI),
              .TRFC_CYC(TRFC), .MAX_CREDIT(MAXC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fault_mode(fault_mode), .pullin_ok(pullin_ok),
    .rd_valid(rd_valid), .rd_erase(rd_erase), .rd_stall(rd_stall),
    .wr_grp(wr_grp), .wr_ready(wr_ready), .ref_cmd_valid(ref_cmd_valid),
    .ref_grp_mask(ref_grp_mask)
  );

  typedef struct { int at; logic [G-1:0] mask; } exp_t;
  exp_t exp_q[$];

  int cyc, checks, fails, m_busy, m_cred, m_ptr, m_sidx, ph_p, ph_t;
  logic [G-1:0] m_mask, cur_busy;
  bit m_rank, cur_rank, started, in_b, done;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, expv);
    end
  endtask

  // Driver: applies inputs and pushes the expected refresh commands
  task automatic step(input bit f, input bit pl);
    int cnt, kind;
    logic [G-1:0] mk;
    @(negedge clk);
    fault_mode = f; pullin_ok = pl;
    rd_valid   = cyc[0] ^ cyc[2];
    wr_grp     = GW'(cyc % G);
    started    = 1'b1;
    #1;
    cnt = cyc % SLOT; kind = 0; mk = '0;
    cur_busy = (m_busy > 0) ? m_mask : '0;
    cur_rank = m_rank && (m_busy > 0);
    if (cnt == SLOT - 1) begin
      if (f) begin
        if (m_sidx == G - 1) begin kind = 2; m_cred = 0; end
      end else if (m_cred > 0) m_cred--;
      else kind = 1;
      m_sidx = (m_sidx + 1) % G;
      if (in_b) ph_t++;
    end else if (!f && pl && m_busy == 0 && cnt < SLOT - TRFC - 1 && m_cred < MAXC) begin
      kind = 1; m_cred++;
    end
    if (kind == 1) begin mk = G'(1) << m_ptr; m_ptr = (m_ptr + 1) % G; end
    if (kind == 2) mk = '1;
    if (kind != 0) begin
      exp_q.push_back('{at: cyc + 1, mask: mk});
      m_busy = TRFC; m_mask = mk; m_rank = (kind == 2);
    end else if (m_busy > 0) m_busy--;
  endtask

  // Monitor: compares outputs against the expectations
  always @(negedge clk) begin
    #2;
    if (started && rst_n) begin
      logic [NCHIP-1:0] ee;
      for (int c = 0; c < NCHIP; c++)
        ee[c] = rd_valid && !cur_rank && cur_busy[c / CPG];
      chk(rd_erase == ee, "R3,R4", "erase mask", int'(rd_erase), int'(ee));
      chk(rd_stall == cur_rank, "R5,R9", "read stall", rd_stall, cur_rank);
      chk(wr_ready == !cur_busy[wr_grp], "R6,R10", "write ready", wr_ready, !cur_busy[wr_grp]);
      if (ref_cmd_valid) begin
        if (exp_q.size() == 0) chk(0, "R2,R7", "unexpected command", ref_grp_mask, 0);
        else begin
          chk(exp_q[0].at == cyc, "R2,R7,R9", "command cycle", cyc, exp_q[0].at);
          chk(ref_grp_mask == exp_q[0].mask, "R2,R3,R9", "command mask",
              int'(ref_grp_mask), int'(exp_q[0].mask));
          void'(exp_q.pop_front());
        end
        if (in_b && $onehot(ref_grp_mask)) ph_p++;
      end else if (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
        chk(0, "R2,R7", "missing command", 0, int'(exp_q[0].mask));
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    rst_n = 1'b0; fault_mode = 1'b0; pullin_ok = 1'b0; rd_valid = 1'b1; wr_grp = '0;
    m_busy = 0; m_cred = 0; m_ptr = 0; m_sidx = 0; m_mask = '0; m_rank = 1'b0;
    cur_busy = '0; cur_rank = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ref_cmd_valid == 1'b0, "R1", "cmd in reset", ref_cmd_valid, 0);
    chk(rd_stall == 1'b0, "R1", "stall in reset", rd_stall, 0);
    chk(rd_erase == '0, "R1", "erase in reset", int'(rd_erase), 0);
    chk(wr_ready == 1'b1, "R1", "wr_ready in reset", wr_ready, 1);
    rst_n = 1'b1;
    // R2 plain rotation
    repeat (519) step(1'b0, 1'b0);
    // R7 and R8 early refresh and credit bank
    in_b = 1'b1;
    repeat (1030) step(1'b0, 1'b1);
    #3;
    in_b = 1'b0;
    chk(ph_p - ph_t == MAXC, "R8", "lead over schedule", ph_p - ph_t, MAXC);
    // R9 fault mode whole-rank refresh
    repeat (800) step(1'b1, 1'b0);
    // back to rotation
    repeat (400) step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    #3;
    chk(exp_q.size() == 0, "R2", "pending commands", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule